// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block collects interrupt signals for a set of levels. Each level has its own fixed priority and its own service location. Every level keeps a small state machine with four states: disarmed, armed, waiting and active. It also keeps an enable flag that is separate from that state. Software commands change these states. A command selects a level by its index and can arm it, disarm it, enable it, disable it, arm and enable it together, trigger it, or take it out of the active state.

The controller looks at the waiting levels that are enabled and not inhibited. Among them it picks the one with the highest priority, and it only picks a level that outranks every level already active. It then asks for the bus. When the bus is granted and the processor says it is at an interruptible point, the controller presents that level's location address and index. The offer stays up until the processor acknowledges it. The acknowledgement carries the processor's new inhibit states, which the controller stores. The acknowledged level then becomes active. A clear command later returns the level to armed or disarmed and loads a fresh copy of the inhibit states. Active levels stack, so the levels can nest.

Top module: `intr_ctrl`

## Requirements
- R1: After reset, every level is disarmed and disabled, the active_o, pending_o and inh_o outputs are zero, and bus_req_o and loc_valid_o are low.
- R2: A disarmed level discards signals and does not remember them later. Command op 1 (arm) moves a disarmed level to armed. Command op 2 (disarm) returns an armed or waiting level to disarmed.
- R3: An armed level becomes waiting when it receives a signal. The signal is a high bit of irq_i sampled on a clock edge, or command op 6 (trigger) on that level. A waiting level shows as its bit in pending_o.
- R4: An active level ignores signals from irq_i and from op 6. Its pending_o bit stays clear.
- R5: Only an enabled level can be selected. Op 3 enables, op 4 disables and op 5 arms and enables. Inhibit bit g blocks the levels with index from g*GRP_SIZE to g*GRP_SIZE+GRP_SIZE-1, for g below INH_W. With the defaults, inh_o[0] blocks levels 0..3 and inh_o[1] blocks levels 4..7.
- R6: When several levels are candidates, the lowest index has the highest priority and is offered first.
- R7: While level j is active, only a level with index below j can be offered. Levels of equal or lower priority wait.
- R8: bus_req_o is high while a candidate waits for an offer. loc_valid_o rises only after a cycle in which bus_gnt_i and cpu_intpt_i are both high. The offer shows loc_idx_o and loc_addr_o = LOC_BASE + index (0x040 + index by default), and it holds until cpu_ack_i.
- R9: When cpu_ack_i is high during an offer, the offered level becomes active, inh_o takes cpu_inh_i, and the offer drops.
- R10: Command op 7 (clear) on an active level moves it to armed when cmd_arg_i is 1, or to disarmed when cmd_arg_i is 0. It also loads inh_o from cmd_inh_i.
- R11: After a higher active level is cleared, a lower active level that is still active keeps blocking the levels below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LEVELS | External signal per level, sampled each cycle |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (1 arm, 2 disarm, 3 enable, 4 disable, 5 arm+enable, 6 trigger, 7 clear) |
| cmd_idx_i | input | 6 | Target level index |
| cmd_arg_i | input | 1 | Clear target: 1 armed, 0 disarmed |
| cmd_inh_i | input | INH_W | Inhibit states loaded by clear |
| bus_req_o | output | 1 | Bus request while a candidate waits |
| bus_gnt_i | input | 1 | Bus grant |
| cpu_intpt_i | input | 1 | Processor is at an interruptible point |
| loc_valid_o | output | 1 | Location offer valid |
| loc_addr_o | output | ADDR_W | Offered interrupt location address |
| loc_idx_o | output | 6 | Offered level index |
| cpu_ack_i | input | 1 | Processor acknowledges the offer |
| cpu_inh_i | input | INH_W | New inhibit states sent with the acknowledge |
| inh_o | output | INH_W | Recorded inhibit states |
| pending_o | output | NUM_LEVELS | Levels in the waiting state |
| active_o | output | NUM_LEVELS | Levels in the active state |

## Verification
The selection logic is tried with several patterns:
- A lone waiting level. This shows the basic offer, with its address and index.
- Two levels raised in the same cycle while the bus is withheld. This checks the priority chain.
- A higher level raised while a lower one is active, and a lower or equal level raised while one is active. These separate preemption from blocking.
- A stack of two active levels where the upper one is cleared. This shows that the lower active level still holds back the levels below it.
- Cases where enable, inhibit, grant or the interruptible point is missing. Each of these must keep the offer back while the candidate stays pending.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    LVL_DISARMED = 2'd0,
    LVL_ARMED    = 2'd1,
    LVL_WAITING  = 2'd2,
    LVL_ACTIVE   = 2'd3
  } lvl_state_e;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ARM     = 3'd1,
    OP_DISARM  = 3'd2,
    OP_ENABLE  = 3'd3,
    OP_DISABLE = 3'd4,
    OP_ARM_EN  = 3'd5,
    OP_TRIGGER = 3'd6,
    OP_CLEAR   = 3'd7
  } cmd_op_e;

  typedef enum logic [1:0] {
    OFF_IDLE = 2'd0,
    OFF_REQ  = 2'd1,
    OFF_HOLD = 2'd2
  } offer_state_e;
endpackage

// File: rtl/intr_level.sv
module intr_level
  import intr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic       arm_i,
  input  logic       disarm_i,
  input  logic       en_set_i,
  input  logic       en_clr_i,
  input  logic       act_i,
  input  logic       clr_i,
  input  logic       clr_arm_i,
  output lvl_state_e state_o,
  output logic       en_o
);
  lvl_state_e state_q, state_d;
  logic       en_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LVL_DISARMED: if (arm_i) state_d = LVL_ARMED;
      LVL_ARMED: begin
        if (disarm_i)   state_d = LVL_DISARMED;
        else if (sig_i) state_d = LVL_WAITING;
      end
      LVL_WAITING: begin
        if (act_i)         state_d = LVL_ACTIVE;
        else if (disarm_i) state_d = LVL_DISARMED;
      end
      LVL_ACTIVE: if (clr_i) state_d = clr_arm_i ? LVL_ARMED : LVL_DISARMED;
      default: state_d = LVL_DISARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LVL_DISARMED;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign en_o    = en_q;
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
  import intr_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int GRP_SIZE   = 4,
  parameter int INH_W      = 2
) (
  input  logic [NUM_LEVELS-1:0] pending_i,
  input  logic [NUM_LEVELS-1:0] enable_i,
  input  logic [NUM_LEVELS-1:0] active_i,
  input  logic [INH_W-1:0]      inh_i,
  output logic                  cand_vld_o,
  output logic [IDX_W-1:0]      cand_idx_o
);
  logic [NUM_LEVELS-1:0] inh_blk;
  logic [NUM_LEVELS-1:0] above_act;
  logic [NUM_LEVELS-1:0] elig;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_inh
    localparam int Grp = i / GRP_SIZE;
    if (Grp < INH_W) begin : g_map
      assign inh_blk[i] = inh_i[Grp];
    end else begin : g_free
      assign inh_blk[i] = 1'b0;
    end
  end

  // a level is held back by any active level of equal or higher priority
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      seen         = seen | active_i[i];
      above_act[i] = seen;
    end
  end

  assign elig = pending_i & enable_i & ~inh_blk & ~above_act;

  always_comb begin
    cand_vld_o = 1'b0;
    cand_idx_o = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        cand_vld_o = 1'b1;
        cand_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_offer.sv
module intr_offer
  import intr_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] LOC_BASE = 12'h040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_vld_i,
  input  logic [IDX_W-1:0]  cand_idx_i,
  input  logic              bus_gnt_i,
  input  logic              cpu_intpt_i,
  input  logic              cpu_ack_i,
  output logic              bus_req_o,
  output logic              loc_valid_o,
  output logic [IDX_W-1:0]  loc_idx_o,
  output logic [ADDR_W-1:0] loc_addr_o,
  output logic              act_o
);
  offer_state_e st_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= OFF_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        OFF_IDLE: if (cand_vld_i) st_q <= OFF_REQ;
        OFF_REQ: begin
          if (!cand_vld_i) st_q <= OFF_IDLE;
          else if (bus_gnt_i && cpu_intpt_i) begin
            st_q  <= OFF_HOLD;
            idx_q <= cand_idx_i;
          end
        end
        OFF_HOLD: if (cpu_ack_i) st_q <= OFF_IDLE;
        default: st_q <= OFF_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (st_q == OFF_REQ);
  assign loc_valid_o = (st_q == OFF_HOLD);
  assign loc_idx_o   = idx_q;
  assign loc_addr_o  = ADDR_W'(LOC_BASE) + ADDR_W'(idx_q);
  assign act_o       = loc_valid_o && cpu_ack_i;
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int          NUM_LEVELS = 16,
  parameter int          GRP_SIZE   = 4,
  parameter int          INH_W      = 2,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] LOC_BASE   = 12'h040
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] irq_i,
  input  logic                  cmd_valid_i,
  input  logic [2:0]            cmd_op_i,
  input  logic [IDX_W-1:0]      cmd_idx_i,
  input  logic                  cmd_arg_i,
  input  logic [INH_W-1:0]      cmd_inh_i,
  output logic                  bus_req_o,
  input  logic                  bus_gnt_i,
  input  logic                  cpu_intpt_i,
  output logic                  loc_valid_o,
  output logic [ADDR_W-1:0]     loc_addr_o,
  output logic [IDX_W-1:0]      loc_idx_o,
  input  logic                  cpu_ack_i,
  input  logic [INH_W-1:0]      cpu_inh_i,
  output logic [INH_W-1:0]      inh_o,
  output logic [NUM_LEVELS-1:0] pending_o,
  output logic [NUM_LEVELS-1:0] active_o
);
  cmd_op_e               op;
  logic [NUM_LEVELS-1:0] cmd_oh, loc_oh, en_vec;
  logic                  cand_vld, act_pulse, clr_hit;
  logic [IDX_W-1:0]      cand_idx;
  logic [INH_W-1:0]      inh_q;

  assign op = cmd_op_e'(cmd_op_i);

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    lvl_state_e st;
    logic       is_tgt;

    assign cmd_oh[i] = (cmd_idx_i == IDX_W'(i));
    assign loc_oh[i] = (loc_idx_o == IDX_W'(i));
    assign is_tgt    = cmd_valid_i && cmd_oh[i];

    intr_level u_lvl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sig_i     (irq_i[i] || (is_tgt && op == OP_TRIGGER)),
      .arm_i     (is_tgt && (op == OP_ARM || op == OP_ARM_EN)),
      .disarm_i  (is_tgt && op == OP_DISARM),
      .en_set_i  (is_tgt && (op == OP_ENABLE || op == OP_ARM_EN)),
      .en_clr_i  (is_tgt && op == OP_DISABLE),
      .act_i     (act_pulse && loc_oh[i]),
      .clr_i     (is_tgt && op == OP_CLEAR),
      .clr_arm_i (cmd_arg_i),
      .state_o   (st),
      .en_o      (en_vec[i])
    );

    assign pending_o[i] = (st == LVL_WAITING);
    assign active_o[i]  = (st == LVL_ACTIVE);
  end

  assign clr_hit = cmd_valid_i && op == OP_CLEAR && |(cmd_oh & active_o);

  intr_prio_sel #(
    .NUM_LEVELS (NUM_LEVELS),
    .GRP_SIZE   (GRP_SIZE),
    .INH_W      (INH_W)
  ) u_sel (
    .pending_i  (pending_o),
    .enable_i   (en_vec),
    .active_i   (active_o),
    .inh_i      (inh_q),
    .cand_vld_o (cand_vld),
    .cand_idx_o (cand_idx)
  );

  intr_offer #(
    .ADDR_W   (ADDR_W),
    .LOC_BASE (LOC_BASE)
  ) u_offer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cand_vld_i  (cand_vld),
    .cand_idx_i  (cand_idx),
    .bus_gnt_i   (bus_gnt_i),
    .cpu_intpt_i (cpu_intpt_i),
    .cpu_ack_i   (cpu_ack_i),
    .bus_req_o   (bus_req_o),
    .loc_valid_o (loc_valid_o),
    .loc_idx_o   (loc_idx_o),
    .loc_addr_o  (loc_addr_o),
    .act_o       (act_pulse)
  );

  // acknowledge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inh_q <= '0;
    else if (act_pulse) inh_q <= cpu_inh_i;
    else if (clr_hit)   inh_q <= cmd_inh_i;
  end

  assign inh_o = inh_q;
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk
  import intr_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int INH_W      = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_valid_i,
  input logic [2:0]            cmd_op_i,
  input logic [IDX_W-1:0]      cmd_idx_i,
  input logic                  bus_gnt_i,
  input logic                  cpu_intpt_i,
  input logic                  loc_valid_o,
  input logic [IDX_W-1:0]      loc_idx_o,
  input logic                  cpu_ack_i,
  input logic [INH_W-1:0]      cpu_inh_i,
  input logic [INH_W-1:0]      inh_o,
  input logic [NUM_LEVELS-1:0] pending_o,
  input logic [NUM_LEVELS-1:0] active_o
);
  logic [NUM_LEVELS-1:0] loc_oh, cmd_oh, hi_mask;

  always_comb begin
    for (int i = 0; i < NUM_LEVELS; i++) begin
      loc_oh[i]  = (loc_idx_o == IDX_W'(i));
      cmd_oh[i]  = (cmd_idx_i == IDX_W'(i));
      hi_mask[i] = (IDX_W'(i) <= loc_idx_o);
    end
  end

  assert_offer_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o && !cpu_ack_i |=> loc_valid_o && $stable(loc_idx_o));

  assert_offer_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loc_valid_o) |-> $past(bus_gnt_i && cpu_intpt_i));

  assert_ack_activates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o && cpu_ack_i && |(pending_o & loc_oh)
    |=> |(active_o & $past(loc_oh)) && inh_o == $past(cpu_inh_i) && !loc_valid_o);

  assert_offer_outranks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o |-> (active_o & hi_mask) == '0);

  assert_clear_leaves_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == 3'd7 && |(cmd_oh & active_o)
    |=> (active_o & $past(cmd_oh)) == '0);
endmodule

bind intr_ctrl intr_ctrl_chk #(
  .NUM_LEVELS (NUM_LEVELS),
  .INH_W      (INH_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_idx_i   (cmd_idx_i),
  .bus_gnt_i   (bus_gnt_i),
  .cpu_intpt_i (cpu_intpt_i),
  .loc_valid_o (loc_valid_o),
  .loc_idx_o   (loc_idx_o),
  .cpu_ack_i   (cpu_ack_i),
  .cpu_inh_i   (cpu_inh_i),
  .inh_o       (inh_o),
  .pending_o   (pending_o),
  .active_o    (active_o)
);

// File: tb/intr_ctrl_test.sv
module intr_ctrl_test;
  localparam int N = 16;
  localparam int IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  irq_i = '0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = '0;
  logic [5:0]    cmd_idx_i = '0;
  logic          cmd_arg_i = 1'b0;
  logic [IW-1:0] cmd_inh_i = '0;
  logic          bus_req_o, bus_gnt_i = 1'b1, cpu_intpt_i = 1'b1;
  logic          loc_valid_o;
  logic [11:0]   loc_addr_o;
  logic [5:0]    loc_idx_o;
  logic          cpu_ack_i = 1'b0;
  logic [IW-1:0] cpu_inh_i = '0;
  logic [IW-1:0] inh_o;
  logic [N-1:0]  pending_o, active_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  intr_ctrl uut (
    .clk_i, .rst_ni, .irq_i, .cmd_valid_i, .cmd_op_i, .cmd_idx_i, .cmd_arg_i,
    .cmd_inh_i, .bus_req_o, .bus_gnt_i, .cpu_intpt_i, .loc_valid_o, .loc_addr_o,
    .loc_idx_o, .cpu_ack_i, .cpu_inh_i, .inh_o, .pending_o, .active_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int idx,
                     input logic arg = 1'b0, input logic [IW-1:0] inh = '0);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_idx_i = 6'(idx);
    cmd_arg_i = arg; cmd_inh_i = inh;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_op_i = 3'd0;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    @(negedge clk_i);
    irq_i = bits;
    @(negedge clk_i);
    irq_i = '0;
  endtask

  task automatic wait_offer(input int idx, input string req);
    int n = 0;
    while (!loc_valid_o && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    chk(loc_valid_o, req, "offer valid", 32'(loc_valid_o), 1);
    chk(loc_idx_o == 6'(idx), req, "offer idx", 32'(loc_idx_o), 32'(idx));
    chk(loc_addr_o == 12'(12'h040 + idx), req, "offer addr", 32'(loc_addr_o), 32'(12'h040 + idx));
  endtask

  task automatic no_offer(input string req);
    bit seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      if (loc_valid_o) seen = 1;
    end
    chk(!seen, req, "no offer", 32'(seen), 0);
  endtask

  task automatic ack(input logic [IW-1:0] inh);
    cpu_ack_i = 1'b1; cpu_inh_i = inh;
    @(negedge clk_i);
    cpu_ack_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(active_o == 0 && pending_o == 0, "R1", "level state", 32'({active_o, pending_o}), 0);
    chk(!loc_valid_o && !bus_req_o && inh_o == 0, "R1", "outputs",
        32'({loc_valid_o, bus_req_o, inh_o}), 0);
  endtask

  task automatic t_disarmed;
    pulse(N'(1) << 3);
    chk(pending_o[3] == 0, "R2", "disarmed irq", 32'(pending_o), 0);
    cmd(3'd6, 3);
    chk(pending_o[3] == 0, "R2", "disarmed trigger", 32'(pending_o), 0);
    cmd(3'd1, 3);
    chk(pending_o[3] == 0, "R2", "not remembered", 32'(pending_o), 0);
  endtask

  task automatic t_armed_no_en;
    pulse(N'(1) << 3);
    chk(pending_o == 16'h0008, "R3", "armed to waiting", 32'(pending_o), 32'h8);
    no_offer("R5");
    chk(!bus_req_o, "R5", "no request when disabled", 32'(bus_req_o), 0);
  endtask

  task automatic t_enable_offer;
    cmd(3'd3, 3);
    wait_offer(3, "R8");
    ack(2'b00);
    chk(active_o == 16'h0008 && pending_o == 0, "R9", "active after ack",
        32'({active_o, pending_o}), 32'h0008_0000);
    chk(!loc_valid_o, "R9", "offer drops", 32'(loc_valid_o), 0);
  endtask

  task automatic t_active_ignore;
    pulse(N'(1) << 3);
    cmd(3'd6, 3);
    chk(pending_o == 0 && active_o == 16'h0008, "R4", "active ignores",
        32'({active_o, pending_o}), 32'h0008_0000);
  endtask

  task automatic t_lower_waits;
    cmd(3'd5, 5);
    pulse(N'(1) << 5);
    chk(pending_o == 16'h0020, "R7", "lower pending", 32'(pending_o), 32'h20);
    no_offer("R7");
  endtask

  task automatic t_preempt;
    cmd(3'd5, 1);
    cmd(3'd6, 1);
    wait_offer(1, "R7");
    ack(2'b00);
    chk(active_o == 16'h000A, "R7", "nested active", 32'(active_o), 32'hA);
  endtask

  task automatic t_nest;
    cmd(3'd7, 1, 1'b1);
    chk(active_o == 16'h0008, "R10", "clear upper", 32'(active_o), 32'h8);
    no_offer("R11");
    pulse(N'(1) << 1);
    wait_offer(1, "R10");
    ack(2'b00);
    cmd(3'd7, 1, 1'b0);
    pulse(N'(1) << 1);
    chk(pending_o[1] == 0, "R10", "cleared to disarmed", 32'(pending_o), 32'h20);
    cmd(3'd7, 3, 1'b0);
    wait_offer(5, "R11");
    ack(2'b00);
    cmd(3'd7, 5, 1'b1);
    chk(active_o == 0, "R10", "all cleared", 32'(active_o), 0);
  endtask

  task automatic t_chain;
    cmd(3'd5, 6);
    cmd(3'd5, 2);
    bus_gnt_i = 1'b0;
    pulse((N'(1) << 6) | (N'(1) << 2));
    @(negedge clk_i);
    chk(bus_req_o && !loc_valid_o, "R8", "request without grant",
        32'({bus_req_o, loc_valid_o}), 32'h2);
    bus_gnt_i = 1'b1;
    wait_offer(2, "R6");
    ack(2'b01);
    chk(inh_o == 2'b01, "R9", "inhibit stored", 32'(inh_o), 1);
    cmd(3'd7, 2, 1'b1, 2'b01);
    chk(inh_o == 2'b01, "R10", "inhibit from clear", 32'(inh_o), 1);
    wait_offer(6, "R6");
    ack(2'b01);
  endtask

  task automatic t_inhibit;
    cmd(3'd5, 0);
    cmd(3'd6, 0);
    chk(pending_o[0], "R5", "level 0 pending", 32'(pending_o), 1);
    no_offer("R5");
    cmd(3'd7, 6, 1'b1, 2'b00);
    chk(inh_o == 0, "R10", "inhibit cleared", 32'(inh_o), 0);
    wait_offer(0, "R5");
    ack(2'b00);
    cmd(3'd7, 0, 1'b1);
  endtask

  task automatic t_intpt_gate;
    cpu_intpt_i = 1'b0;
    cmd(3'd6, 0);
    no_offer("R8");
    chk(bus_req_o, "R8", "request held", 32'(bus_req_o), 1);
    cpu_intpt_i = 1'b1;
    wait_offer(0, "R8");
    repeat (3) @(negedge clk_i);
    chk(loc_valid_o && loc_idx_o == 0, "R8", "offer held until ack",
        32'({loc_valid_o, loc_idx_o}), 32'h40);
    ack(2'b00);
    cmd(3'd7, 0, 1'b1);
  endtask

  task automatic t_disable;
    cmd(3'd4, 0);
    cmd(3'd6, 0);
    chk(pending_o[0], "R5", "disabled still pends", 32'(pending_o), 1);
    no_offer("R5");
    cmd(3'd2, 0);
    chk(pending_o[0] == 0, "R2", "waiting disarmed", 32'(pending_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_disarmed();
    t_armed_no_en();
    t_enable_offer();
    t_active_ignore();
    t_lower_waits();
    t_preempt();
    t_nest();
    t_chain();
    t_inhibit();
    t_intpt_gate();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule